// File: doc/BRIEF.md
# Gated Dual-Channel Count Summer

The block measures two pulse streams over a fixed measurement window and reports how many rising edges each stream had, plus the sum of the two counts. Everything runs on a single fast system clock. A timebase divider produces a periodic gate that is high for the first half of each period. While the gate is high, two counters advance on the rising edges of the two pulse inputs. Both inputs are asynchronous, so each one passes through a synchronizer and an edge detector first.

The two counts feed an adder built from a chain of 4-bit stages. When the gate falls, the counts, the sum and the carry out of the top stage are loaded into holding registers, and a one-cycle strobe marks the new result. The counters are cleared later, at three quarters of the period. This leaves a quiet interval in which nothing moves, and the captured result is never read from an adder whose inputs are still changing. The captured outputs stay fixed until the next capture.

With the default 100 MHz clock the period is 1/16 s, so the gate window is 1/32 s. A 1 kHz input then reads about 31 and a 512 Hz input about 16. The period is a parameter, which lets a testbench shorten the window while keeping its shape and phase order.

Top module: `gated_count_summer`

## Requirements
- R1: While reset is asserted and after it is released, until the first capture, all captured outputs read 0 and `valid_o` is low.
- R2: `valid_o` is high for exactly one clock per gate period, and successive strobes are exactly `GATE_PERIOD` clocks apart.
- R3: For a steady pulse train of period P clocks on either input, the captured count of that channel lies within one of `(GATE_PERIOD/2)/P`.
- R4: A channel count saturates at 255 and does not wrap when more edges arrive in one window.
- R5: `sum_o` equals the low 8 bits of `count_a_o + count_b_o`, both taken from the same window. Bit 0 is the least significant bit. Bits 3:0 come from the first 4-bit stage, whose carry-in is 0, and bits 7:4 come from the second stage, which takes the first stage's carry.
- R6: `ovf_o` is 1 exactly when `count_a_o + count_b_o` exceeds 255, that is, it is the carry out of the top stage.
- R7: The captured outputs change only in the cycle in which `valid_o` is high, and hold their value between captures.
- R8: The counters are cleared between windows and only while the gate is low. A window's result does not include edges from an earlier window.
- R9: An input held low for a whole window reads a count of exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_a | input | 1 | Asynchronous pulse input, channel A |
| pulse_b | input | 1 | Asynchronous pulse input, channel B |
| count_a_o | output | 8 | Captured edge count of channel A |
| count_b_o | output | 8 | Captured edge count of channel B |
| sum_o | output | 8 | Captured 8-bit sum of the two counts |
| ovf_o | output | 1 | Captured carry out of the top adder stage |
| valid_o | output | 1 | One-cycle strobe marking a new capture |

## Verification
Randomly chosen pulse periods on the two channels show whether each count follows its own input frequency within one count. They also show whether the sum matches the two captured counts, including windows where the total passes 255 and sets the overflow flag. Directed windows cover several corners. Both inputs idle gives an exact zero. Both inputs toggling at full speed shows that saturation happens instead of wrap-around, and produces the overflow sum 254. One saturated and one idle channel gives the carry-free maximum of 255. A saturated window followed by an idle window shows whether the clear really separates windows. Throughout every run, the strobe spacing and the stability of the outputs between strobes are also checked.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  // Width of one adder stage and of a channel count.
  localparam int unsigned STAGE_W = 4;
  localparam int unsigned COUNT_W = 8;

  // Captured result of one window.
  typedef struct packed {
    logic               ovf;
    logic [COUNT_W-1:0] sum;
    logic [COUNT_W-1:0] cnt_a;
    logic [COUNT_W-1:0] cnt_b;
  } result_t;
endpackage

// File: rtl/gcs_timebase.sv
module gcs_timebase #(
  parameter int unsigned PERIOD = 6_250_000
) (
  input  logic clk,
  input  logic rst,
  output logic gate,
  output logic capture,
  output logic clear
);
  localparam int unsigned HALF   = PERIOD / 2;
  localparam int unsigned CLR_AT = (3 * PERIOD) / 4;
  localparam int unsigned TB_W   = $clog2(PERIOD);

  logic [TB_W-1:0] phase_q;
  logic            gate_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= '0;
      gate_d_q <= 1'b0;
    end else begin
      phase_q  <= (phase_q == TB_W'(PERIOD - 1)) ? '0 : phase_q + 1'b1;
      gate_d_q <= gate;
    end
  end

  assign gate    = (phase_q < TB_W'(HALF));
  // first clock after the gate falls
  assign capture = gate_d_q && !gate;
  assign clear   = (phase_q == TB_W'(CLR_AT));

  // R8
  clear_outside_gate_chk: assert property (@(posedge clk) disable iff (rst)
    clear |-> !gate);
  // R8
  clear_after_capture_chk: assert property (@(posedge clk) disable iff (rst)
    capture |-> !clear);
endmodule

// File: rtl/gcs_edge_sync.sv
module gcs_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], din};
  end

  // compare the last synchronized stage with its delayed copy
  assign rise = chain_q[STAGES-1] && !chain_q[STAGES];

  // R3
  single_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/gcs_sat_counter.sv
module gcs_sat_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)                 cnt_q <= '0;
    else if (en && (cnt_q != TOP))  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R4
  saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == TOP) && !clr |=> cnt_q == TOP);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en && !clr |=> $stable(cnt_q));
endmodule

// File: rtl/gcs_nibble_add.sv
module gcs_nibble_add #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  always_comb {co, s} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
endmodule

// File: rtl/gated_count_summer.sv
module gated_count_summer
  import gcs_pkg::*;
#(
  parameter int unsigned GATE_PERIOD = 6_250_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pulse_a,
  input  logic               pulse_b,
  output logic [COUNT_W-1:0] count_a_o,
  output logic [COUNT_W-1:0] count_b_o,
  output logic [COUNT_W-1:0] sum_o,
  output logic               ovf_o,
  output logic               valid_o
);
  localparam int unsigned N_STAGES = COUNT_W / STAGE_W;

  logic gate, capture, clear;
  logic rise_a, rise_b;
  logic [COUNT_W-1:0] cnt_a, cnt_b, sum_w;
  logic [N_STAGES:0]  carry;
  result_t res_q;
  logic    valid_q;

  gcs_timebase #(.PERIOD(GATE_PERIOD)) u_tb (
    .clk(clk), .rst(rst), .gate(gate), .capture(capture), .clear(clear)
  );

  gcs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst(rst), .din(pulse_a), .rise(rise_a)
  );
  gcs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst(rst), .din(pulse_b), .rise(rise_b)
  );

  gcs_sat_counter #(.W(COUNT_W)) u_cnt_a (
    .clk(clk), .rst(rst), .clr(clear), .en(gate && rise_a), .cnt(cnt_a)
  );
  gcs_sat_counter #(.W(COUNT_W)) u_cnt_b (
    .clk(clk), .rst(rst), .clr(clear), .en(gate && rise_b), .cnt(cnt_b)
  );

  // chain of 4-bit stages, lowest nibble first, carry-in 0
  assign carry[0] = 1'b0;
  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    gcs_nibble_add #(.W(STAGE_W)) u_add (
      .a (cnt_a[g*STAGE_W +: STAGE_W]),
      .b (cnt_b[g*STAGE_W +: STAGE_W]),
      .ci(carry[g]),
      .s (sum_w[g*STAGE_W +: STAGE_W]),
      .co(carry[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= capture;
      if (capture) begin
        res_q.cnt_a <= cnt_a;
        res_q.cnt_b <= cnt_b;
        res_q.sum   <= sum_w;
        res_q.ovf   <= carry[N_STAGES];
      end
    end
  end

  assign count_a_o = res_q.cnt_a;
  assign count_b_o = res_q.cnt_b;
  assign sum_o     = res_q.sum;
  assign ovf_o     = res_q.ovf;
  assign valid_o   = valid_q;

  // R2
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
  // R5
  sum_match_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> ({res_q.ovf, res_q.sum} == {1'b0, res_q.cnt_a} + {1'b0, res_q.cnt_b}));
  // R7
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_q) |-> valid_q);
endmodule

// File: tb/sim_gated_count_summer.sv
`timescale 1ns/1ps
module sim_gated_count_summer;
  localparam int PERIOD = 1200;
  localparam int HALF   = PERIOD / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pa = 1'b0, pb = 1'b0;
  logic [7:0] ca, cb, sm;
  logic ovf, vld;

  int h_a = 0, h_b = 0;
  int n_chk = 0, n_bad = 0;
  int cyc = 0, last_vld = -1;
  bit done = 0;

  always #5 clk = ~clk;

  gated_count_summer #(.GATE_PERIOD(PERIOD), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .pulse_a(pa), .pulse_b(pb),
    .count_a_o(ca), .count_b_o(cb), .sum_o(sm), .ovf_o(ovf), .valid_o(vld)
  );

  // channel generators: toggle every h clocks, h == 0 keeps the line low
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (h_a == 0) begin pa = 1'b0; ph = 0; end
      else begin ph++; if (ph >= h_a) begin ph = 0; pa = ~pa; end end
    end
  end
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (h_b == 0) begin pb = 1'b0; ph = 0; end
      else begin ph++; if (ph >= h_b) begin ph = 0; pb = ~pb; end end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lo_bound(input int h);
    int n;
    if (h == 0) return 0;
    n = HALF / (2 * h) - 1;
    if (n > 255) n = 255;
    return (n < 0) ? 0 : n;
  endfunction

  function automatic int hi_bound(input int h);
    int n;
    if (h == 0) return 0;
    n = HALF / (2 * h) + 1;
    return (n > 255) ? 255 : n;
  endfunction

  // wait for the next strobe, checking output hold (R7) and spacing (R2)
  task automatic wait_window();
    logic [24:0] prev;
    bit moved = 0;
    int start = cyc;
    prev = {ca, cb, sm, ovf};
    forever begin
      @(negedge clk);
      cyc++;
      if (vld) break;
      if ({ca, cb, sm, ovf} != prev) moved = 1;
      if (cyc - start > 3 * PERIOD) break;
    end
    // R7 outputs unchanged without a strobe
    chk(!moved, "R7", moved, 0);
    // R2 strobe present
    chk(vld === 1'b1, "R2", vld, 1);
    if (last_vld >= 0)
      chk(cyc - last_vld == PERIOD, "R2", cyc - last_vld, PERIOD);
    last_vld = cyc;
  endtask

  task automatic check_result(input int ea_lo, input int ea_hi,
                              input int eb_lo, input int eb_hi, input string rq);
    int tot;
    chk(ca >= ea_lo && ca <= ea_hi, rq, ca, ea_lo);
    chk(cb >= eb_lo && cb <= eb_hi, rq, cb, eb_lo);
    tot = int'(ca) + int'(cb);
    // R5 sum of the two captured counts, low 8 bits
    chk(sm == tot[7:0], "R5", sm, tot % 256);
    // R6 carry out of bit 7
    chk(ovf == (tot > 255), "R6", ovf, tot > 255);
    @(negedge clk); cyc++;
    // R2 strobe lasts one clock
    chk(vld == 1'b0, "R2", vld, 0);
  endtask

  task automatic run(input int a, input int b, input string rq);
    h_a = a; h_b = b;
    wait_window();
    check_result(lo_bound(a), hi_bound(a), lo_bound(b), hi_bound(b), rq);
  endtask

  initial begin
    void'($urandom(32'd1234));
    h_a = 0; h_b = 0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk({ca, cb, sm, ovf, vld} == '0, "R1", {ca, cb, sm, ovf, vld}, 0);
    rst = 1'b0;
    repeat (HALF / 2) begin @(negedge clk); cyc++; end
    chk({ca, cb, sm, ovf, vld} == '0, "R1", {ca, cb, sm, ovf, vld}, 0);

    // R9 idle inputs read exactly zero
    run(0, 0, "R9");
    // R3 typical frequencies
    run(16, 32, "R3");
    // R4 full-rate toggling saturates, sum 254 with overflow
    run(1, 1, "R4");
    chk(sm == 8'd254 && ovf, "R6", {ovf, sm}, 9'h1FE);
    // R8 window after a saturated one starts from zero
    run(0, 0, "R8");
    // R4 one saturated, one idle: 255 without carry
    run(1, 0, "R4");
    chk(sm == 8'd255 && !ovf, "R5", {ovf, sm}, 255);
    // R3 random periods on both channels
    for (int i = 0; i < 10; i++) begin
      int a = 2 + int'($urandom_range(0, 38));
      int b = 2 + int'($urandom_range(0, 38));
      run(a, b, "R3");
    end
    done = 1;
  end

  initial begin
    int w = 0;
    while (!done && w < 150_000) begin @(posedge clk); w++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", w, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule